// File: doc/BRIEF.md
# SAR ADC Control Sequencer

This block is the digital half of an eight-input, 10-bit successive-approximation converter. Software reaches it through four byte-wide registers: a control register, which holds the input selector, the port-configuration field, the completion flag and the start bit; a clock-select register; and two read-only result bytes. The block drives the input selector and port configuration to the analog front end. It also derives the converter power enable and presents a 10-bit trial code to an external DAC and comparator, whose one-bit answer it reads back on every step.

A conversion is started with a two-edge handshake on the start bit. Setting the bit resets the converter and raises the busy flag (the flag reads 1 while no result is ready). Clearing the bit then launches ten approximation steps, most significant bit first. Each step lasts one conversion-clock period, and that period is set by the clock-select field. When the last step finishes, the flag drops to 0. If the interrupt input is enabled, a one-cycle request pulse is issued in the same cycle. When the port-configuration field is all zero, the converter is powered off and the handshake is ignored.

Top module: `sarSequencer`

## Requirements
- R1: After reset the register reads are: result low 0x00, result high 0x00, control 0x40, clock select 0x00. The outputs irqReq, powerEn and dacCode are 0.
- R2: Register addresses are 0 = result low, 1 = result high, 2 = control, 3 = clock select. Control bits are [2:0] input select, [5:3] port configuration, [6] completion flag and [7] start. Writing start 0→1 with a non-zero port configuration sets the flag to 1 and holds dacCode at 0 while start stays 1.
- R3: A following write of start 1→0 begins a conversion. The flag reads 0 exactly 10×D clock cycles after the edge that takes that write. The result is the largest code whose trial level the comparator (cmpIn = input ≥ trial) accepts, which is the input level itself.
- R4: The clock-select bits [1:0] set the step period D: 00 → 2 cycles, 01 → 8, 10 → 32, 11 → 32. The value is captured when the conversion begins.
- R5: The first trial code of every conversion is 0x200 and appears in the cycle after the launching edge.
- R6: The result high byte holds result bits 9..2. The result low byte holds result bits 1..0 in its bits 7..6 and reads zero below them.
- R7: irqReq pulses high for exactly one cycle, in the cycle the flag falls, and only when irqEnable is 1.
- R8: A start 0→1 write during a conversion aborts it. The flag stays 1, dacCode returns to 0 and no request is raised. A later start 1→0 write runs a complete new conversion.
- R9: powerEn is 0 whenever the port configuration is 000. Writing configuration 000 aborts a running conversion, and start edges written with configuration 000 change neither the flag nor dacCode.
- R10: Writes to the result bytes and to the completion flag bit have no effect on what reads back.
- R11: Clock-select bits [7:2] read as zero whatever is written. Bits [1:0] read back as written.
- R12: chanSel and portCfg always equal control bits [2:0] and [5:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| irqEnable | input | 1 | Enables the completion request |
| cmpIn | input | 1 | Comparator: 1 when input ≥ trial level |
| chanSel | output | 3 | Analog input selector |
| portCfg | output | 3 | Port configuration to pin circuits |
| powerEn | output | 1 | Converter analog power enable |
| dacCode | output | 10 | Trial code to the DAC, 0 when idle |
| irqReq | output | 1 | One-cycle completion request |

## Verification
Conversions are run with a comparator model that holds a per-input level. The extreme levels 0 and 1023 and the neighbours 511 and 512 show whether every bit, MSB first, is kept or dropped correctly. Seeded random levels, inputs, configurations and clock selects cover the remaining codes. Because all four clock-select codes are used, the completion cycle count separates a wrong divider from a wrong step count. Directed sequences restart a running conversion, power it down mid-flight and write read-only fields, so that aborts and ignored writes can be told apart from ordinary completion.

// File: rtl/sarSeqPkg.sv
package sarSeqPkg;
  localparam int RES_W = 10;
  localparam int SEL_W = 3;
  localparam int CFG_W = 3;
  localparam int IDX_W = $clog2(RES_W);

  localparam logic [1:0] ADDR_RES_LO = 2'd0;
  localparam logic [1:0] ADDR_RES_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_CLKSEL = 2'd3;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_CONV  = 2'd2
  } seqStateT;

  typedef struct packed {
    logic armConv;
    logic startConv;
    logic haltConv;
  } seqStrobeT;
endpackage

// File: rtl/sarSeqCtrl.sv
module sarSeqCtrl
  import sarSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic [1:0]       rdAddr,
  output logic [7:0]       rdData,
  input  logic             irqEnable,
  input  logic [RES_W-1:0] resultCode,
  input  logic             convDone,
  output seqStrobeT        strobes,
  output logic [SEL_W-1:0] chanSel,
  output logic [CFG_W-1:0] portCfg,
  output logic             powerEn,
  output logic [1:0]       clkSel,
  output logic             eocb,
  output logic             irqReq,
  output logic             convActive
);
  seqStateT state;
  logic [SEL_W-1:0] chanReg;
  logic [CFG_W-1:0] cfgReg;
  logic startReg, eocbReg, irqReg;
  logic [1:0] clkSelReg;

  logic ctrlWr, newStart, newPowered, riseStart, fallStart, powerDrop;
  logic [CFG_W-1:0] newCfg;

  always_comb begin
    ctrlWr     = wrEn && (wrAddr == ADDR_CTRL);
    newStart   = wrData[7];
    newCfg     = wrData[5:3];
    newPowered = (newCfg != '0);
    riseStart  = ctrlWr && newPowered && newStart && !startReg;
    fallStart  = ctrlWr && newPowered && !newStart && startReg && (state == SEQ_ARMED);
    powerDrop  = ctrlWr && !newPowered;
    strobes.armConv   = riseStart;
    strobes.startConv = fallStart;
    strobes.haltConv  = powerDrop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      chanReg   <= '0;
      cfgReg    <= '0;
      startReg  <= 1'b0;
      eocbReg   <= 1'b1;
      irqReg    <= 1'b0;
      clkSelReg <= 2'b00;
    end else begin
      irqReg <= 1'b0;
      if (ctrlWr) begin
        chanReg  <= wrData[2:0];
        cfgReg   <= newCfg;
        startReg <= newStart;
      end
      if (wrEn && (wrAddr == ADDR_CLKSEL)) clkSelReg <= wrData[1:0];
      if (powerDrop) begin
        state <= SEQ_IDLE;
      end else if (riseStart) begin
        state   <= SEQ_ARMED;
        eocbReg <= 1'b1;
      end else if (fallStart) begin
        state <= SEQ_CONV;
      end else if ((state == SEQ_CONV) && convDone) begin
        state   <= SEQ_IDLE;
        eocbReg <= 1'b0;
        irqReg  <= irqEnable;
      end
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_RES_LO: rdData = {resultCode[1:0], 6'b0};
      ADDR_RES_HI: rdData = resultCode[RES_W-1:2];
      ADDR_CTRL:   rdData = {startReg, eocbReg, cfgReg, chanReg};
      default:     rdData = {6'b0, clkSelReg};
    endcase
  end

  assign chanSel    = chanReg;
  assign portCfg    = cfgReg;
  assign powerEn    = (cfgReg != '0);
  assign clkSel     = clkSelReg;
  assign eocb       = eocbReg;
  assign irqReq     = irqReg;
  assign convActive = (state == SEQ_CONV);
endmodule

// File: rtl/sarSeqDatapath.sv
module sarSeqDatapath
  import sarSeqPkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobeT        strobes,
  input  logic [1:0]       clkSel,
  input  logic             cmpIn,
  output logic [RES_W-1:0] dacCode,
  output logic [RES_W-1:0] resultCode,
  output logic             convDone
);
  localparam int DIV_MAX1 = (DIV_FAST > DIV_MID) ? DIV_FAST : DIV_MID;
  localparam int DIV_MAX  = (DIV_MAX1 > DIV_SLOW) ? DIV_MAX1 : DIV_SLOW;
  localparam int CNT_W    = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic running;
  logic [CNT_W-1:0] divCnt, divLimit, selLimit;
  logic [IDX_W-1:0] bitIdx;
  logic [RES_W-1:0] sar, trialMask;
  logic tick;

  always_comb begin
    unique case (clkSel)
      2'b00:   selLimit = CNT_W'(DIV_FAST - 1);
      2'b01:   selLimit = CNT_W'(DIV_MID - 1);
      default: selLimit = CNT_W'(DIV_SLOW - 1);
    endcase
  end

  for (genvar b = 0; b < RES_W; b++) begin : g_mask
    assign trialMask[b] = running && (bitIdx == IDX_W'(b));
  end

  assign tick       = running && (divCnt == divLimit);
  assign convDone   = tick && (bitIdx == '0);
  assign dacCode    = running ? (sar | trialMask) : '0;
  assign resultCode = sar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      divCnt   <= '0;
      divLimit <= '0;
      bitIdx   <= '0;
      sar      <= '0;
    end else if (strobes.armConv) begin
      running <= 1'b0;
      sar     <= '0;
    end else if (strobes.haltConv) begin
      running <= 1'b0;
    end else if (strobes.startConv) begin
      running  <= 1'b1;
      sar      <= '0;
      bitIdx   <= IDX_W'(RES_W - 1);
      divCnt   <= '0;
      divLimit <= selLimit;
    end else if (running) begin
      if (tick) begin
        sar[bitIdx] <= cmpIn;
        divCnt      <= '0;
        if (bitIdx == '0) running <= 1'b0;
        else bitIdx <= bitIdx - 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sarSequencer.sv
module sarSequencer
  import sarSeqPkg::*;
#(
  parameter int DIV_FAST = 2,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [1:0]  rdAddr,
  output logic [7:0]  rdData,
  input  logic        irqEnable,
  input  logic        cmpIn,
  output logic [2:0]  chanSel,
  output logic [2:0]  portCfg,
  output logic        powerEn,
  output logic [9:0]  dacCode,
  output logic        irqReq
);
  seqStrobeT strobes;
  logic [RES_W-1:0] resultCode;
  logic [1:0] clkSel;
  logic convDone, eocbFlag, convActive;

  sarSeqCtrl ctrlInst (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqEnable(irqEnable),
    .resultCode(resultCode), .convDone(convDone), .strobes(strobes),
    .chanSel(chanSel), .portCfg(portCfg), .powerEn(powerEn), .clkSel(clkSel),
    .eocb(eocbFlag), .irqReq(irqReq), .convActive(convActive)
  );

  sarSeqDatapath #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) dpInst (
    .clk(clk), .rstN(rstN), .strobes(strobes), .clkSel(clkSel), .cmpIn(cmpIn),
    .dacCode(dacCode), .resultCode(resultCode), .convDone(convDone)
  );
endmodule

// File: rtl/sarSequencerChk.sv
module sarSequencerChk (
  input logic       clk,
  input logic       rstN,
  input logic       irqReq,
  input logic [9:0] dacCode,
  input logic       powerEn,
  input logic       eocb,
  input logic       convActive
);
  // R7
  irq_on_flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $fell(eocb));
  // R7
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);
  // R9
  dac_needs_power_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dacCode != 10'd0) |-> powerEn);
  // R5
  first_trial_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convActive) |-> (dacCode == 10'h200));
  // R3
  busy_during_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    convActive |-> eocb);
endmodule

bind sarSequencer sarSequencerChk chkInst (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .dacCode(dacCode),
  .powerEn(powerEn), .eocb(eocbFlag), .convActive(convActive)
);

// File: tb/sarSequencer_test.sv
`timescale 1ns/1ps
module sarSequencer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [1:0] rdAddr = 2'd0;
  logic [7:0] rdData;
  logic irqEnable = 1'b0;
  logic cmpIn;
  logic [2:0] chanSel, portCfg;
  logic powerEn, irqReq;
  logic [9:0] dacCode;
  logic [9:0] analog [8];

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assign cmpIn = (analog[chanSel] >= dacCode);

  sarSequencer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqEnable(irqEnable), .cmpIn(cmpIn),
    .chanSel(chanSel), .portCfg(portCfg), .powerEn(powerEn), .dacCode(dacCode),
    .irqReq(irqReq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  function automatic int divFor(input int sel);
    case (sel & 3)
      0: return 2;
      1: return 8;
      default: return 32;
    endcase
  endfunction

  function automatic logic [7:0] expHigh(input logic [9:0] lvl);
    return lvl[9:2];
  endfunction

  function automatic logic [7:0] expLow(input logic [9:0] lvl);
    return {lvl[1:0], 6'b0};
  endfunction

  task automatic checkVal(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  // Waits up to 'span' cycles; returns the cycle the flag first read 0 and the cycle of the irq pulse.
  task automatic watch(input int span, output int doneAt, output int irqAt, output int irqCount);
    logic [7:0] r;
    doneAt = -1; irqAt = -1; irqCount = 0;
    for (int n = 1; n <= span; n++) begin
      @(negedge clk);
      readReg(2'd2, r);
      if (!r[6] && doneAt < 0) doneAt = n;
      if (irqReq) begin
        irqCount++;
        if (irqAt < 0) irqAt = n;
      end
    end
  endtask

  task automatic runConv(input int ch, input int cfg, input int sel, input int lvl, input bit ie);
    logic [7:0] r;
    int d, doneAt, irqAt, irqCount;
    logic [2:0] c3, cf3;
    c3 = 3'(ch); cf3 = 3'(cfg);
    analog[c3] = 10'(lvl);
    irqEnable = ie;
    d = divFor(sel);
    writeReg(2'd3, 8'(sel));
    writeReg(2'd2, {1'b1, 1'b0, cf3, c3});
    readReg(2'd2, r);
    checkVal("R2 flag set on start rise", r[6], 1);
    checkVal("R2 no trial while start high", dacCode, 0);
    checkVal("R12 chanSel follows control", chanSel, c3);
    writeReg(2'd2, {1'b0, 1'b0, cf3, c3});
    checkVal("R5 first trial code", dacCode, 10'h200);
    watch(10 * d + 3, doneAt, irqAt, irqCount);
    checkVal("R3 R4 completion cycle", doneAt, 10 * d);
    checkVal("R7 irq cycle", irqAt, ie ? 10 * d : -1);
    checkVal("R7 irq count", irqCount, ie ? 1 : 0);
    readReg(2'd1, r);
    checkVal("R3 R6 result high", r, expHigh(10'(lvl)));
    readReg(2'd0, r);
    checkVal("R3 R6 result low", r, expLow(10'(lvl)));
  endtask

  initial begin
    logic [7:0] r;
    int doneAt, irqAt, irqCount, bad;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 8; i++) analog[i] = 10'd0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readReg(2'd0, r); checkVal("R1 reset result low", r, 8'h00);
    readReg(2'd1, r); checkVal("R1 reset result high", r, 8'h00);
    readReg(2'd2, r); checkVal("R1 reset control", r, 8'h40);
    readReg(2'd3, r); checkVal("R1 reset clock select", r, 8'h00);
    checkVal("R1 reset outputs", {irqReq, powerEn, dacCode}, 0);

    // Directed edge levels, every clock-select code
    runConv(0, 1, 0, 0, 1'b1);
    runConv(7, 7, 1, 1023, 1'b1);
    runConv(3, 2, 2, 512, 1'b0);
    runConv(4, 4, 3, 511, 1'b1);

    // Random conversions
    for (int k = 0; k < 25; k++)
      runConv($urandom_range(7), $urandom_range(7, 1), $urandom_range(3),
              $urandom_range(1023), 1'($urandom_range(1)));

    // R10: read-only result bytes and flag
    runConv(5, 3, 0, 10'h2A5, 1'b0);
    writeReg(2'd0, 8'hFF);
    writeReg(2'd1, 8'hFF);
    readReg(2'd1, r); checkVal("R10 high byte unwritable", r, 8'hA9);
    readReg(2'd0, r); checkVal("R10 low byte unwritable", r, 8'h40);
    writeReg(2'd2, {1'b0, 1'b1, 3'd3, 3'd5});
    readReg(2'd2, r); checkVal("R10 flag unwritable", r[6], 0);

    // R11: clock-select reserved bits
    writeReg(2'd3, 8'hFF);
    readReg(2'd3, r); checkVal("R11 clock select readback", r, 8'h03);
    writeReg(2'd3, 8'h80);
    readReg(2'd3, r); checkVal("R11 reserved bit reads zero", r, 8'h00);

    // R12: outputs follow control fields
    writeReg(2'd2, {1'b0, 1'b0, 3'b101, 3'b110});
    checkVal("R12 chanSel", chanSel, 6);
    checkVal("R12 portCfg", portCfg, 5);
    checkVal("R9 power on with config", powerEn, 1);

    // R9: handshake ignored while powered off
    writeReg(2'd2, {1'b1, 1'b0, 3'b000, 3'd2});
    checkVal("R9 power off", powerEn, 0);
    readReg(2'd2, r); checkVal("R9 flag unchanged by rise when off", r[6], 0);
    writeReg(2'd2, {1'b0, 1'b0, 3'b000, 3'd2});
    bad = 0;
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      if (dacCode != 0 || irqReq) bad++;
    end
    checkVal("R9 no conversion when off", bad, 0);
    readReg(2'd2, r); checkVal("R9 flag unchanged by fall when off", r[6], 0);

    // R9: power drop mid conversion
    irqEnable = 1'b1;
    analog[1] = 10'd700;
    writeReg(2'd3, 8'h01);
    writeReg(2'd2, {1'b1, 1'b0, 3'd5, 3'd1});
    writeReg(2'd2, {1'b0, 1'b0, 3'd5, 3'd1});
    repeat (30) @(negedge clk);
    writeReg(2'd2, {1'b0, 1'b0, 3'd0, 3'd1});
    checkVal("R9 trial cleared on power drop", dacCode, 0);
    watch(120, doneAt, irqAt, irqCount);
    checkVal("R9 no irq after power drop", irqCount, 0);
    checkVal("R9 flag stays busy after power drop", doneAt, -1);

    // R8: restart during conversion
    analog[2] = 10'd321;
    writeReg(2'd3, 8'h02);
    writeReg(2'd2, {1'b1, 1'b0, 3'd2, 3'd2});
    writeReg(2'd2, {1'b0, 1'b0, 3'd2, 3'd2});
    repeat (40) @(negedge clk);
    writeReg(2'd2, {1'b1, 1'b0, 3'd2, 3'd2});
    readReg(2'd2, r); checkVal("R8 flag busy after abort", r[6], 1);
    checkVal("R8 trial cleared after abort", dacCode, 0);
    watch(400, doneAt, irqAt, irqCount);
    checkVal("R8 no completion after abort", doneAt, -1);
    checkVal("R8 no irq after abort", irqCount, 0);
    writeReg(2'd2, {1'b0, 1'b0, 3'd2, 3'd2});
    watch(323, doneAt, irqAt, irqCount);
    checkVal("R8 restarted conversion completes", doneAt, 320);
    checkVal("R8 restarted irq", irqAt, 320);
    readReg(2'd1, r); checkVal("R8 restarted result high", r, expHigh(10'd321));
    readReg(2'd0, r); checkVal("R8 restarted result low", r, expLow(10'd321));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule